// File: doc/BRIEF.md
# Write-Only I2C Word Receiver

This block is an I2C target that only accepts writes. It runs on a fast system clock and oversamples the two bus lines. Each line passes through a two-flop synchronizer and a glitch filter before any edge is detected. The filter rejects pulses shorter than a set number of system-clock cycles, so spikes up to 50 ns are ignored.

The target's 7-bit address comes from three ternary select inputs. It also answers a fixed global address. A write frame has three parts: a START, the address byte with the direction bit low, and exactly three data bytes. The block acknowledges the address and each of the three data bytes by raising an active-high pull-low enable for the external open-drain SDA driver. The enable is held for the ninth clock of each byte.

When the ninth clock of the third data byte falls, the block presents the assembled 24-bit word on `word_o` and pulses `word_valid_o` for one cycle. Reads, foreign addresses and surplus bytes never get an acknowledge. A START or STOP that arrives mid-frame throws away any partial word.

Top module: `i2c_word_rx`

## Requirements
- R1: After reset, `sda_pull_o` is 0, `word_valid_o` is 0 and `word_o` is 0.
- R2: Each select input uses the code 0 = tied low, 1 = floating, 2 = tied high, and code 3 is treated as 2. With idx = 9*sel2 + 3*sel1 + sel0, the own address is {idx/4+1 in bits 6:4, 00 in bits 3:2, idx%4 in bits 1:0}, running from 0x10 to 0x72. The block acknowledges a write byte whose upper seven bits equal this address.
- R3: The global address 0x73 is acknowledged for writes under every select setting.
- R4: An address byte whose least significant bit (the direction flag) is 1 is never acknowledged, and none of the bytes that follow it in that frame are acknowledged.
- R5: After an accepted address, each of the next three data bytes is acknowledged. `sda_pull_o` rises only while the filtered SCL is low, stays high through the ninth clock, and drops at the falling edge that ends that clock.
- R6: A fourth or later data byte in the same frame is not acknowledged. Its contents are dropped, `word_o` keeps the previous word and no further strobe follows.
- R7: Bits are sampled on SCL rising edges, MSB first. `word_o` equals {data byte 1, data byte 2, data byte 3} and is updated together with a `word_valid_o` pulse exactly one cycle wide at the falling edge of the ninth clock of byte 3. `word_o` does not change at any other time.
- R8: A pulse on SCL or SDA that is shorter than FILT_LEN system clocks (default 6, i.e. 60 ns at 100 MHz) has no effect on decoding.
- R9: A repeated START or a STOP before the third data byte completes discards the partial word. No strobe is produced, and a new frame after a repeated START is received normally.
- R10: If the address matches neither the own nor the global address, the address byte and every later byte of that frame are left unacknowledged and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel2 | input | 2 | Ternary select for address digit 2 (weight 9) |
| addr_sel1 | input | 2 | Ternary select for address digit 1 (weight 3) |
| addr_sel0 | input | 2 | Ternary select for address digit 0 (weight 1) |
| sda_pull_o | output | 1 | High to drive SDA low (open-drain acknowledge) |
| word_o | output | 24 | Last complete received word, first byte in the top bits |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
On every cycle, the assertions check that the strobe is one cycle wide and that the output word moves only with it. They also check that the pull-low enable starts only while the filtered clock is low, that it is driven only inside an acknowledge slot, and that a STOP is never followed by a strobe. Other behaviours can only be shown by the bench's scenarios, because they depend on whole bus frames: the ternary address mapping, the global address, refusal of reads and of foreign addresses, the NACK on a surplus byte, glitch rejection, and dropping a partial word on a repeated START or STOP.

// File: rtl/i2c_word_rx_pkg.sv
package i2c_word_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_ACK    = 2'd2,
    ST_IGNORE = 2'd3
  } rx_state_t;

  localparam logic [6:0] GLOBAL_ADDR = 7'h73;

  // Ternary selects to 7-bit address; code 3 is clamped to "high".
  function automatic logic [6:0] tern_addr(input logic [1:0] s2,
                                           input logic [1:0] s1,
                                           input logic [1:0] s0);
    logic [1:0] v2, v1, v0;
    logic [4:0] idx;
    logic [2:0] hi;
    v2  = (s2 == 2'd3) ? 2'd2 : s2;
    v1  = (s1 == 2'd3) ? 2'd2 : s1;
    v0  = (s0 == 2'd3) ? 2'd2 : s0;
    idx = 5'(5'd9 * 5'(v2) + 5'd3 * 5'(v1) + 5'(v0));
    hi  = idx[4:2] + 3'd1;
    return {hi, 2'b00, idx[1:0]};
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q;
  logic          f_q, f_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    f_d   = f_q;
    cnt_d = '0;
    if (s2_q != f_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        f_d   = s2_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      f_q   <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= raw_i;
      s2_q  <= s1_q;
      f_q   <= f_d;
      cnt_q <= cnt_d;
    end
  end

  assign filt_o = f_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_word_fsm.sv
module i2c_word_fsm
  import i2c_word_rx_pkg::*;
#(
  parameter int DATA_BYTES = 3,
  localparam int WORD_W    = 8 * DATA_BYTES,
  localparam int BCW       = $clog2(DATA_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_f,
  input  logic [6:0]        dev_addr,
  output logic              sda_pull,
  output logic [WORD_W-1:0] word,
  output logic              word_valid,
  output rx_state_t         state
);
  rx_state_t         state_q, state_d;
  logic [3:0]        bit_q, bit_d;
  logic [BCW-1:0]    byte_q, byte_d;
  logic [7:0]        shift_q, shift_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              ack_q, ack_d;
  logic              pull_q, pull_d;
  logic              valid_q, valid_d;
  logic              accept;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    shift_d = shift_q;
    acc_d   = acc_q;
    word_d  = word_q;
    ack_d   = ack_q;
    pull_d  = pull_q;
    valid_d = 1'b0;
    accept  = 1'b0;
    if (start_evt) begin
      state_d = ST_SHIFT;
      bit_d   = '0;
      byte_d  = '0;
      pull_d  = 1'b0;
    end else if (stop_evt) begin
      state_d = ST_IDLE;
      bit_d   = '0;
      byte_d  = '0;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        ST_SHIFT: begin
          if (scl_rise && bit_q < 4'd8) begin
            shift_d = {shift_q[6:0], sda_f};
            bit_d   = bit_q + 4'd1;
          end
          if (scl_fall && bit_q == 4'd8) begin
            if (byte_q == '0) begin
              accept = ((shift_q[7:1] == dev_addr) || (shift_q[7:1] == GLOBAL_ADDR))
                       && !shift_q[0];
            end else if (byte_q <= BCW'(DATA_BYTES)) begin
              accept = 1'b1;
              acc_d  = WORD_W'({acc_q, shift_q});
            end
            ack_d   = accept;
            pull_d  = accept;
            state_d = ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            bit_d  = '0;
            if (ack_q) begin
              state_d = ST_SHIFT;
              byte_d  = byte_q + 1'b1;
              if (byte_q == BCW'(DATA_BYTES)) begin
                valid_d = 1'b1;
                word_d  = acc_q;
              end
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      shift_q <= '0;
      acc_q   <= '0;
      word_q  <= '0;
      ack_q   <= 1'b0;
      pull_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      shift_q <= shift_d;
      acc_q   <= acc_d;
      word_q  <= word_d;
      ack_q   <= ack_d;
      pull_q  <= pull_d;
      valid_q <= valid_d;
    end
  end

  assign sda_pull   = pull_q;
  assign word       = word_q;
  assign word_valid = valid_q;
  assign state      = state_q;
endmodule

// File: rtl/i2c_word_rx.sv
module i2c_word_rx
  import i2c_word_rx_pkg::*;
#(
  parameter int FILT_LEN   = 6,
  parameter int DATA_BYTES = 3,
  localparam int WORD_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel2,
  input  logic [1:0]        addr_sel1,
  input  logic [1:0]        addr_sel0,
  output logic              sda_pull_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int NLINES = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NLINES-1:0] line_raw, line_f;
  logic              scl_f, sda_f;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic [6:0]        dev_addr;
  rx_state_t         fsm_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .raw_i  (line_raw[g]),
      .filt_o (line_f[g])
    );
  end

  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  i2c_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  assign dev_addr = tern_addr(addr_sel2, addr_sel1, addr_sel0);

  i2c_word_fsm #(.DATA_BYTES(DATA_BYTES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .sda_f      (sda_f),
    .dev_addr   (dev_addr),
    .sda_pull   (sda_pull_o),
    .word       (word_o),
    .word_valid (word_valid_o),
    .state      (fsm_state)
  );
endmodule

// File: rtl/i2c_word_rx_chk.sv
module i2c_word_rx_chk
  import i2c_word_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              stop_evt,
  input rx_state_t         state,
  input logic              sda_pull_o,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o
);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  a_r5_pull_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_f);

  a_r5_pull_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (state == ST_ACK));

  a_r9_stop_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !word_valid_o);
endmodule

bind i2c_word_rx i2c_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .scl_f        (scl_f),
  .stop_evt     (stop_evt),
  .state        (fsm_state),
  .sda_pull_o   (sda_pull_o),
  .word_o       (word_o),
  .word_valid_o (word_valid_o)
);

// File: tb/i2c_word_rx_tb.sv
module i2c_word_rx_tb;
  localparam int Q  = 20;
  localparam int WD = 190000;
  localparam int NV = 7;
  // {sel2, sel1, sel0, addr7, rw, d1, d2, d3}
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 7'h10, 1'b0, 24'hABCDEF},
    {2'd2, 2'd2, 2'd2, 7'h72, 1'b0, 24'h000000},
    {2'd1, 2'd2, 2'd0, 7'h43, 1'b0, 24'hFFFFFF},
    {2'd2, 2'd0, 2'd1, 7'h53, 1'b0, 24'h123456},
    {2'd0, 2'd1, 2'd1, 7'h21, 1'b0, 24'h99AA77},
    {2'd1, 2'd1, 2'd1, 7'h73, 1'b0, 24'h5AA53C},
    {2'd0, 2'd0, 2'd2, 7'h12, 1'b1, 24'h445566}
  };

  logic        clk, rst_n, scl_m, sda_m;
  logic [1:0]  sel2, sel1, sel0;
  logic        sda_pull_o, word_valid_o;
  logic [23:0] word_o;
  int          total, bad, vcnt, cyc, glitch_mode;
  bit          done;

  i2c_word_rx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_m & ~sda_pull_o),
    .addr_sel2(sel2), .addr_sel1(sel1), .addr_sel0(sel0),
    .sda_pull_o(sda_pull_o), .word_o(word_o), .word_valid_o(word_valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (word_valid_o) vcnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [6:0] exp_addr(input logic [1:0] a, b, c);
    int v2, v1, v0, idx;
    v2 = (a == 2'd3) ? 2 : int'(a);
    v1 = (b == 2'd3) ? 2 : int'(b);
    v0 = (c == 2'd3) ? 2 : int'(c);
    idx = 9 * v2 + 3 * v1 + v0;
    return 7'((idx / 4 + 1) * 16 + idx % 4);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;
    if (glitch_mode == 1) begin
      tick(5); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(Q - 9);
    end else tick(Q);
    scl_m = 1'b1;
    if (glitch_mode == 2) begin
      tick(5); sda_m = ~b; tick(4); sda_m = b; tick(Q - 9);
    end else tick(Q);
    scl_m = 1'b0; tick(Q);
    glitch_mode = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    ack = sda_pull_o;
    tick(Q / 2);
    scl_m = 1'b0; tick(Q);
    chk(sda_pull_o == 1'b0, "R5 pull released after slot", {31'd0, sda_pull_o}, 32'd0);
  endtask

  task automatic do_xfer(input logic [6:0] a, input logic rw, input logic [31:0] d,
                         input int nb, input bit stop, output logic [4:0] acks);
    logic ak;
    acks = '0;
    i2c_start();
    send_byte({a, rw}, ak);
    acks[0] = ak;
    for (int i = 0; i < nb; i++) begin
      send_byte(d[31 - 8 * i -: 8], ak);
      acks[i + 1] = ak;
    end
    if (stop) i2c_stop();
  endtask

  initial begin
    logic [4:0] acks;
    logic [23:0] prev;
    int v0;
    total = 0; bad = 0; vcnt = 0; cyc = 0; glitch_mode = 0; done = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; sel2 = 2'd0; sel1 = 2'd0; sel0 = 2'd0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk(sda_pull_o == 1'b0, "R1 pull", {31'd0, sda_pull_o}, 0);
    chk(word_valid_o == 1'b0, "R1 valid", {31'd0, word_valid_o}, 0);
    chk(word_o == 24'd0, "R1 word", {8'd0, word_o}, 0);

    // Vector table: R2 R3 R4 R5 R7 R10
    for (int k = 0; k < NV; k++) begin
      logic [6:0] a;
      logic rw, exp_ack;
      logic [23:0] d;
      {sel2, sel1, sel0, a, rw, d} = VEC[k];
      exp_ack = ((a == exp_addr(sel2, sel1, sel0)) || (a == 7'h73)) && !rw;
      tick(4);
      v0 = vcnt;
      prev = word_o;
      do_xfer(a, rw, {d, 8'h00}, 3, 1'b1, acks);
      chk(acks[0] == exp_ack, "R2/R3/R4/R10 address ack", {27'd0, acks}, {31'd0, exp_ack});
      chk(acks[3:1] == {3{exp_ack}}, "R5 data acks", {27'd0, acks}, {29'd0, {3{exp_ack}}});
      chk((vcnt - v0) == (exp_ack ? 1 : 0), "R7 strobe count", vcnt - v0, exp_ack ? 1 : 0);
      chk(word_o == (exp_ack ? d : prev), "R7 word", {8'd0, word_o}, {8'd0, exp_ack ? d : prev});
    end

    // R6 surplus byte
    sel2 = 2'd0; sel1 = 2'd0; sel0 = 2'd0;
    tick(4);
    v0 = vcnt;
    do_xfer(7'h10, 1'b0, 32'h11223344, 4, 1'b0, acks);
    chk(acks == 5'b01111, "R6 fourth byte NACK", {27'd0, acks}, 32'h0F);
    chk(word_o == 24'h112233, "R6 word kept", {8'd0, word_o}, 32'h112233);
    i2c_stop();
    chk(vcnt - v0 == 1, "R6 single strobe", vcnt - v0, 1);

    // R8 SCL glitch inside a bit's low phase
    v0 = vcnt;
    glitch_mode = 1;
    do_xfer(7'h10, 1'b0, 32'hC3A50F00, 3, 1'b1, acks);
    chk(acks == 5'b01111, "R8 acks with SCL glitch", {27'd0, acks}, 32'h0F);
    chk(word_o == 24'hC3A50F && vcnt - v0 == 1, "R8 word with SCL glitch", {8'd0, word_o}, 32'hC3A50F);
    // R8 SDA glitch while SCL high
    v0 = vcnt;
    glitch_mode = 2;
    do_xfer(7'h10, 1'b0, 32'h0FF07E00, 3, 1'b1, acks);
    chk(acks == 5'b01111, "R8 acks with SDA glitch", {27'd0, acks}, 32'h0F);
    chk(word_o == 24'h0FF07E && vcnt - v0 == 1, "R8 word with SDA glitch", {8'd0, word_o}, 32'h0FF07E);

    // R9 STOP after two data bytes
    v0 = vcnt;
    do_xfer(7'h10, 1'b0, 32'hDEAD0000, 2, 1'b1, acks);
    tick(Q);
    chk(vcnt == v0, "R9 no strobe after STOP", vcnt - v0, 0);
    chk(word_o == 24'h0FF07E, "R9 word unchanged", {8'd0, word_o}, 32'h0FF07E);
    // R9 repeated START after two data bytes, then full frame
    do_xfer(7'h10, 1'b0, 32'hBEEF0000, 2, 1'b0, acks);
    sda_m = 1'b1; tick(Q);
    do_xfer(7'h73, 1'b0, 32'h13579B00, 3, 1'b1, acks);
    chk(acks == 5'b01111, "R9 acks after restart", {27'd0, acks}, 32'h0F);
    chk(vcnt - v0 == 1, "R9 one strobe only", vcnt - v0, 1);
    chk(word_o == 24'h13579B, "R9 word after restart", {8'd0, word_o}, 32'h13579B);

    // R2 clamp code 3 to high: idx 26 -> 0x72
    sel2 = 2'd3; sel1 = 2'd3; sel0 = 2'd3;
    tick(4);
    do_xfer(7'h72, 1'b0, 32'h24681300, 3, 1'b1, acks);
    chk(acks == 5'b01111 && word_o == 24'h246813, "R2 code 3 clamp", {27'd0, acks}, 32'h0F);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule